// File: doc/BRIEF.md
# LUT Logic Cluster

The block is a cluster of eight programmable logic cells. Each cell looks up a
value from a 16-entry truth table using four data bits. It can also form a
ripple-carry bit and can register its result in a flip-flop. All cells share
one clock, one clock enable and one set/reset line. Static configuration ports
set these per cell:
- the truth table;
- whether the carry generator is active;
- whether the output is registered;
- whether set/reset acts synchronously or asynchronously;
- the value loaded on set/reset.

A single configuration bit picks the active clock edge for the whole cluster.

Adjacent cells can be chained. A per-cell select replaces the third data bit
(in2) with the previous cell's unregistered table value. A second select
replaces the fourth data bit (in3) with the incoming carry. The carry comes
from the previous cell, or from the cluster carry input for cell 0. A path
that has no source reads as 0. This holds for the cascade into cell 0 and for
the carry of a cell whose carry generator is off.

Top module: `lut_cluster`

## Requirements
- R1: With `carry_en[k]`=1, `carry_out[k]` = (a1&a2)|((a1|a2)&ci). Here a1 and a2 are the cell's in1 and in2 after the cascade select, and ci is `chain_in` for cell 0 or `carry_out[k-1]` otherwise. With `carry_en[k]`=0, `carry_out[k]` is 0.
- R2: The table value of cell k is `lut_init[k*16 + idx]`. The index is idx = {in3,in2,in1,in0}, with in0 = `din[4k]` as the least significant bit.
- R3: With `ff_en[k]`=0, `cell_out[k]` equals the table value in the same cycle, without any clock edge.
- R4: With `ff_en[k]`=1 and `ff_async[k]`=0, an active edge with `clk_en`=1 loads `rst_val[k]` when `set_rst`=1, and loads the table value otherwise. With `clk_en`=0 the output holds.
- R5: With `ff_en[k]`=1 and `ff_async[k]`=1, a rise of `set_rst` drives `rst_val[k]` onto `cell_out[k]` at once, with no clock edge. The output stays there while `set_rst` is high. Otherwise the cell loads the table value on an active edge with `clk_en`=1.
- R6: The active edge is the rising edge of `clk` when `clk_inv`=0 and the falling edge when `clk_inv`=1.
- R7: With `in2_from_prev[k]`=1, in2 of cell k is the unregistered table value of cell k-1. For cell 0 it reads 0.
- R8: With `in3_from_chain[k]`=1, in3 of cell k is the carry into cell k: `chain_in` for cell 0, otherwise `carry_out[k-1]`. The carry of a cell whose generator is off reads 0.
- R9: A truth table of all zeros gives a constant 0 output, and one of all ones gives a constant 1 output, whatever the data bits.
- R10: Registered cells show 0 from power-up until their first load or set/reset event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Cluster clock |
| clk_inv | input | 1 | Config: 1 selects the falling edge as active |
| clk_en | input | 1 | Shared clock enable |
| set_rst | input | 1 | Shared set/reset |
| chain_in | input | 1 | Cluster carry input to cell 0 |
| din | input | NCELL*LUT_K | Four data bits per cell, cell k at [4k+3:4k] |
| lut_init | input | NCELL*2^LUT_K | Config: truth tables, cell k at [16k+15:16k] |
| carry_en | input | NCELL | Config: carry generator enable per cell |
| ff_en | input | NCELL | Config: register the cell output |
| ff_async | input | NCELL | Config: 1 = asynchronous set/reset |
| rst_val | input | NCELL | Config: value loaded by set/reset |
| in2_from_prev | input | NCELL | Config: in2 from previous cell's table value |
| in3_from_chain | input | NCELL | Config: in3 from the carry chain |
| cell_out | output | NCELL | Registered or combinational cell outputs |
| carry_out | output | NCELL | Carry outputs |

## Verification
Table values, cascade paths and carries settle within the cycle in which the
inputs change. The bench drives inputs 2 ns after an active edge and reads
these results 1 ns later. Registered outputs change only at the next active
edge, so the bench reads them 2 ns after that edge, using a model state it
updates from the values present just before the edge. There are two
exceptions, both checked before any edge occurs. An asynchronous set/reset
takes effect within the same delta. In falling-edge mode the bench checks
separately that the rising edge in between leaves the outputs unchanged.

// File: rtl/lut_cluster_pkg.sv
package lut_cluster_pkg;

   // Majority of three: generate when both operands set, propagate when either is.
   function automatic logic carry_maj(input logic a, input logic b, input logic ci);
      return (a & b) | ((a | b) & ci);
   endfunction

   // Index positions of the routed data bits inside a cell's select vector.
   localparam int CASC_BIT  = 2;
   localparam int CHAIN_BIT = 3;
   localparam int ADD_A_BIT = 1;
   localparam int ADD_B_BIT = 2;

endpackage

// File: rtl/lut_cell_lut.sv
module lut_cell_lut #(
   parameter int LUT_K = 4
) (
   input  logic [(1<<LUT_K)-1:0] table_bits,
   input  logic [LUT_K-1:0]      sel,
   output logic                  y
);
   localparam int LUT_N = 1 << LUT_K;
   localparam int NODES = 2*LUT_N - 1;

   // Flattened binary mux tree: level l starts at offset 2N - 2*(N>>l).
   logic [NODES-1:0] node;

   assign node[LUT_N-1:0] = table_bits;

   for (genvar l = 0; l < LUT_K; l++) begin : g_lvl
      localparam int SRC = 2*LUT_N - 2*(LUT_N >> l);
      localparam int DST = 2*LUT_N - 2*(LUT_N >> (l+1));
      for (genvar j = 0; j < (LUT_N >> (l+1)); j++) begin : g_mux
         assign node[DST+j] = sel[l] ? node[SRC+2*j+1] : node[SRC+2*j];
      end
   end

   assign y = node[NODES-1];
endmodule

// File: rtl/lut_cell_carry.sv
module lut_cell_carry
   import lut_cluster_pkg::*;
#(
   parameter bit HAS_CARRY = 1'b1
) (
   input  logic en,
   input  logic a,
   input  logic b,
   input  logic ci,
   output logic co
);
   if (HAS_CARRY) begin : g_carry
      assign co = en & carry_maj(a, b, ci);
   end else begin : g_nocarry
      logic unused_in;
      assign unused_in = ^{en, a, b, ci};
      assign co = 1'b0;
   end
endmodule

// File: rtl/lut_cell_ff.sv
module lut_cell_ff (
   input  logic clk_eff,
   input  logic clk_en,
   input  logic set_rst,
   input  logic ff_en,
   input  logic ff_async,
   input  logic rst_val,
   input  logic d,
   output logic q_out
);
   logic q = 1'b0;
   logic arst;

   // Only the asynchronous mode lets set/reset reach the flop's async pin.
   assign arst = set_rst & ff_async;

   always_ff @(posedge clk_eff or posedge arst) begin
      if (arst)
         q <= rst_val;
      else if (clk_en)
         q <= set_rst ? rst_val : d;
   end

   assign q_out = ff_en ? q : d;
endmodule

// File: rtl/lut_cluster.sv
module lut_cluster
   import lut_cluster_pkg::*;
#(
   parameter int NCELL     = 8,
   parameter int LUT_K     = 4,
   parameter bit HAS_CARRY = 1'b1
) (
   input  logic                            clk,
   input  logic                            clk_inv,
   input  logic                            clk_en,
   input  logic                            set_rst,
   input  logic                            chain_in,
   input  logic [NCELL*LUT_K-1:0]          din,
   input  logic [NCELL*(1<<LUT_K)-1:0]     lut_init,
   input  logic [NCELL-1:0]                carry_en,
   input  logic [NCELL-1:0]                ff_en,
   input  logic [NCELL-1:0]                ff_async,
   input  logic [NCELL-1:0]                rst_val,
   input  logic [NCELL-1:0]                in2_from_prev,
   input  logic [NCELL-1:0]                in3_from_chain,
   output logic [NCELL-1:0]                cell_out,
   output logic [NCELL-1:0]                carry_out
);
   localparam int LUT_N = 1 << LUT_K;

   if (NCELL < 1) begin : g_bad_ncell
      $error("lut_cluster: NCELL must be at least 1");
   end
   if (LUT_K < 4) begin : g_bad_k
      $error("lut_cluster: LUT_K must be at least 4 for cascade and chain inputs");
   end

   logic clk_eff;
   assign clk_eff = clk ^ clk_inv;

   // Unpacked chains keep the ripple paths free of packed self-dependence.
   logic lut_w   [NCELL];
   logic carry_w [NCELL];
   logic [NCELL-1:0] lut_q;
   logic [NCELL-1:0] in1_w;
   logic [NCELL-1:0] in2_w;

   for (genvar k = 0; k < NCELL; k++) begin : g_cell
      logic             ci;
      logic             casc;
      logic [LUT_K-1:0] sel;

      if (k == 0) begin : g_head
         assign ci   = chain_in;
         assign casc = 1'b0;
      end else begin : g_link
         assign ci   = carry_w[k-1];
         assign casc = lut_w[k-1];
      end

      always_comb begin
         sel = din[k*LUT_K +: LUT_K];
         if (in2_from_prev[k])  sel[CASC_BIT]  = casc;
         if (in3_from_chain[k]) sel[CHAIN_BIT] = ci;
      end

      lut_cell_lut #(.LUT_K(LUT_K)) u_lut (
         .table_bits (lut_init[k*LUT_N +: LUT_N]),
         .sel        (sel),
         .y          (lut_w[k])
      );

      lut_cell_carry #(.HAS_CARRY(HAS_CARRY)) u_carry (
         .en (carry_en[k]),
         .a  (sel[ADD_A_BIT]),
         .b  (sel[ADD_B_BIT]),
         .ci (ci),
         .co (carry_w[k])
      );

      lut_cell_ff u_ff (
         .clk_eff  (clk_eff),
         .clk_en   (clk_en),
         .set_rst  (set_rst),
         .ff_en    (ff_en[k]),
         .ff_async (ff_async[k]),
         .rst_val  (rst_val[k]),
         .d        (lut_w[k]),
         .q_out    (cell_out[k])
      );

      assign carry_out[k] = carry_w[k];
      assign lut_q[k]     = lut_w[k];
      assign in1_w[k]     = sel[ADD_A_BIT];
      assign in2_w[k]     = sel[ADD_B_BIT];
   end
endmodule

// File: rtl/lut_cluster_chk.sv
module lut_cluster_chk #(
   parameter int NCELL     = 8,
   parameter bit HAS_CARRY = 1'b1
) (
   input logic             clk,
   input logic             clk_eff,
   input logic             clk_en,
   input logic             set_rst,
   input logic [NCELL-1:0] ff_en,
   input logic [NCELL-1:0] ff_async,
   input logic [NCELL-1:0] rst_val,
   input logic [NCELL-1:0] carry_en,
   input logic [NCELL-1:0] in1_w,
   input logic [NCELL-1:0] in2_w,
   input logic [NCELL-1:0] lut_q,
   input logic [NCELL-1:0] cell_out,
   input logic [NCELL-1:0] carry_out
);
   for (genvar k = 0; k < NCELL; k++) begin : g_chk
      AST_BYPASS_COMB: assert property (@(posedge clk) disable iff (set_rst)
         !ff_en[k] |-> cell_out[k] == lut_q[k]); // R3

      AST_CARRY_OFF: assert property (@(posedge clk) disable iff (set_rst)
         !carry_en[k] |-> !carry_out[k]); // R1

      if (HAS_CARRY) begin : g_cy
         AST_CARRY_GEN: assert property (@(posedge clk) disable iff (set_rst)
            carry_en[k] && in1_w[k] && in2_w[k] |-> carry_out[k]); // R1
         AST_CARRY_KILL: assert property (@(posedge clk) disable iff (set_rst)
            carry_en[k] && !in1_w[k] && !in2_w[k] |-> !carry_out[k]); // R1
      end

      AST_HOLD_NO_EN: assert property (@(posedge clk_eff) disable iff (set_rst)
         $past(ff_en[k] && !clk_en && !set_rst) && ff_en[k]
         |-> cell_out[k] == $past(cell_out[k])); // R4

      AST_SYNC_LOAD: assert property (@(posedge clk_eff) disable iff (ff_async[k])
         $past(ff_en[k] && !ff_async[k] && clk_en && set_rst) && ff_en[k]
         |-> cell_out[k] == $past(rst_val[k])); // R4

      AST_ASYNC_FORCE: assert property (@(posedge clk) disable iff (!ff_async[k])
         ff_en[k] && set_rst |-> cell_out[k] == rst_val[k]); // R5
   end
endmodule

bind lut_cluster lut_cluster_chk #(.NCELL(NCELL), .HAS_CARRY(HAS_CARRY)) u_chk (.*);

// File: tb/sim_lut_cluster.sv
module sim_lut_cluster;
   localparam int NC = 8;
   localparam int K  = 4;
   localparam int N  = 16;
   localparam int STEPS = 30;

   logic            clk = 1'b0;
   logic            clk_inv = 1'b0;
   logic            clk_en = 1'b0;
   logic            set_rst = 1'b0;
   logic            chain_in = 1'b0;
   logic [NC*K-1:0] din = '0;
   logic [NC*N-1:0] lut_init = '0;
   logic [NC-1:0]   carry_en = '0;
   logic [NC-1:0]   ff_en = '1;
   logic [NC-1:0]   ff_async = '0;
   logic [NC-1:0]   rst_val = '0;
   logic [NC-1:0]   in2_from_prev = '0;
   logic [NC-1:0]   in3_from_chain = '0;
   logic [NC-1:0]   cell_out;
   logic [NC-1:0]   carry_out;

   lut_cluster u0 (.*);

   always #4 clk = ~clk;   // 125 MHz

   int n_chk = 0;
   int n_err = 0;
   logic [NC-1:0] mq = '0;      // model flop state
   logic [31:0]   rng = 32'h1;

   // bit 32: falling-edge mode; bits 31:0: seed
   localparam logic [32:0] RUNS [0:7] = '{
      {1'b0, 32'h0000_1D2B}, {1'b1, 32'h5EED_0001}, {1'b0, 32'hC0FF_EE11},
      {1'b1, 32'h8BAD_F00D}, {1'b0, 32'h1234_5678}, {1'b1, 32'h0F0F_3C3C},
      {1'b0, 32'hA5A5_0707}, {1'b1, 32'h7777_1111}};

   function automatic logic [31:0] nxt();
      rng ^= rng << 13;
      rng ^= rng >> 17;
      rng ^= rng << 5;
      return rng;
   endfunction

   task automatic chk(input string req, input logic [NC-1:0] act, input logic [NC-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Reference of the combinational part, written from R1, R2, R7, R8.
   task automatic model(output logic [NC-1:0] lv, output logic [NC-1:0] cv);
      lv = '0;
      cv = '0;
      for (int k = 0; k < NC; k++) begin
         logic ci, casc;
         logic [K-1:0] s;
         ci   = (k == 0) ? chain_in : cv[k-1];
         casc = (k == 0) ? 1'b0 : lv[k-1];
         s = din[k*K +: K];
         if (in2_from_prev[k])  s[2] = casc;
         if (in3_from_chain[k]) s[3] = ci;
         lv[k] = lut_init[k*N + int'(s)];
         cv[k] = carry_en[k] & ((s[1] & s[2]) | ((s[1] | s[2]) & ci));
      end
   endtask

   task automatic wait_active();
      if (clk_inv) @(negedge clk); else @(posedge clk);
   endtask

   // Called with inputs just driven, at least 3 ns before the next active edge.
   task automatic step(input string tag);
      logic [NC-1:0] lv, cv, nq;
      for (int k = 0; k < NC; k++)
         if (ff_async[k] && set_rst) mq[k] = rst_val[k];
      #1;
      model(lv, cv);
      chk({tag, " comb"}, cell_out, (ff_en & mq) | (~ff_en & lv));
      chk("R1 carry", carry_out, cv);
      for (int k = 0; k < NC; k++) begin
         if (ff_async[k] && set_rst) nq[k] = rst_val[k];
         else if (clk_en)            nq[k] = set_rst ? rst_val[k] : lv[k];
         else                        nq[k] = mq[k];
      end
      wait_active();
      mq = nq;
      #2;
      chk("R4 registered", cell_out, (ff_en & mq) | (~ff_en & lv));
   endtask

   task automatic set_pol(input logic neg);
      clk_en  = 1'b0;
      set_rst = 1'b0;
      clk_inv = neg;
      wait_active();
      #2;
   endtask

   task automatic fill(input logic [N-1:0] t);
      for (int k = 0; k < NC; k++) lut_init[k*N +: N] = t;
   endtask

   task automatic fill_din(input logic [K-1:0] v);
      for (int k = 0; k < NC; k++) din[k*K +: K] = v;
   endtask

   initial begin
      #(200000 * 8);
      n_err++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

   initial begin
      #1;
      chk("R10 power-up", cell_out, 8'h00);
      @(posedge clk);
      #2;

      // Random configurations in both clock polarities.
      for (int r = 0; r < 8; r++) begin
         set_pol(RUNS[r][32]);
         rng = RUNS[r][31:0];
         for (int k = 0; k < NC; k++) lut_init[k*N +: N] = nxt()[N-1:0];
         ff_en          = nxt()[NC-1:0];
         ff_async       = nxt()[NC-1:0];
         rst_val        = nxt()[NC-1:0];
         carry_en       = nxt()[NC-1:0];
         in2_from_prev  = nxt()[NC-1:0];
         in3_from_chain = nxt()[NC-1:0];
         for (int s = 0; s < STEPS; s++) begin
            logic [31:0] v;
            v = nxt();
            din      = nxt();
            chain_in = v[0];
            clk_en   = v[2:1] != 2'b00;
            set_rst  = v[5:3] == 3'b000;
            step(RUNS[r][32] ? "R6/R2/R3 neg" : "R2/R3 pos");
         end
      end
      set_pol(1'b0);
      ff_en = '0; ff_async = '0; carry_en = '0;
      in2_from_prev = '0; in3_from_chain = '0; chain_in = 1'b0;

      // R9: constant tables
      fill(16'h0000); din = 32'hDEAD_BEEF;
      #1; chk("R9 zeros", cell_out, 8'h00);
      fill(16'hFFFF); din = 32'h1357_9BDF;
      #1; chk("R9 ones", cell_out, 8'hFF);
      step("R9");

      // R2: index order, only entry 11 ({in3,in2,in1,in0}=1011) set
      fill(16'h0800);
      fill_din(4'hB); #1; chk("R2 idx 1011", cell_out, 8'hFF);
      fill_din(4'hA); #1; chk("R2 idx 1010", cell_out, 8'h00);
      fill_din(4'h3); #1; chk("R2 idx 0011", cell_out, 8'h00);
      step("R2");

      // R1: ripple propagate and generate
      carry_en = '1;
      fill_din(4'b0010); chain_in = 1'b1;
      #1; chk("R1 propagate 1", carry_out, 8'hFF);
      chain_in = 1'b0;
      #1; chk("R1 propagate 0", carry_out, 8'h00);
      fill_din(4'b0110);
      #1; chk("R1 generate", carry_out, 8'hFF);
      fill_din(4'b0010); chain_in = 1'b1; carry_en[3] = 1'b0;
      #1; chk("R1 disabled cell", carry_out, 8'h07);
      step("R1");

      // R7: cascade of table values (table = in2)
      carry_en = '0; fill(16'hF0F0); fill_din(4'b0100); in2_from_prev = '1;
      #1; chk("R7 cell0 reads 0", cell_out, 8'h00);
      in2_from_prev[0] = 1'b0;
      #1; chk("R7 ripple", cell_out, 8'hFF);
      lut_init[3*N +: N] = 16'h0F0F;
      #1; chk("R7 inverter in chain", cell_out, 8'h07);
      step("R7");

      // R8: carry into in3 (table = in3), carry generators off
      in2_from_prev = '0; fill(16'hFF00); fill_din(4'b1000);
      in3_from_chain = '1; chain_in = 1'b1;
      #1; chk("R8 chain", cell_out, 8'h01);
      in3_from_chain = '0;
      #1; chk("R8 external", cell_out, 8'hFF);
      step("R8");

      // R4: synchronous set/reset, enable and hold
      fill(16'hFFFF); ff_en = '1; ff_async = '0; rst_val = '0; clk_en = 1'b1;
      step("R4 load");
      chk("R4 loaded table", cell_out, 8'hFF);
      set_rst = 1'b1;
      #1; chk("R4 sync waits for edge", cell_out, 8'hFF);
      step("R4 sync");
      chk("R4 reset value", cell_out, 8'h00);
      set_rst = 1'b0; clk_en = 1'b0;
      step("R4 hold");
      chk("R4 held", cell_out, 8'h00);
      clk_en = 1'b1;
      step("R4 reload");
      chk("R4 reloaded", cell_out, 8'hFF);

      // R5: asynchronous set/reset
      fill(16'h0000); step("R5 prep");
      ff_async = '1; rst_val = 8'hA5; clk_en = 1'b0; set_rst = 1'b1;
      mq = 8'hA5;
      #1; chk("R5 immediate", cell_out, 8'hA5);
      step("R5");
      set_rst = 1'b0;
      step("R5 release");
      chk("R5 holds after release", cell_out, 8'hA5);

      // R6: falling-edge mode
      ff_async = '0; fill(16'hFFFF);
      set_pol(1'b1);
      clk_en = 1'b1;
      @(posedge clk); #1;
      chk("R6 rising edge ignored", cell_out, 8'hA5);
      @(negedge clk); #1;
      chk("R6 falling edge loads", cell_out, 8'hFF);
      mq = 8'hFF;
      #1;
      set_pol(1'b0);

      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end
endmodule